// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a byte-addressed serial memory that answers as a target on a two-wire I2C bus. It runs from a fast system clock and oversamples SCL and SDA. It finds START and STOP conditions and decodes a device address whose upper nibble is the fixed type code 1010. It takes a two-byte word address and supports page writes and three read forms: current-address, random and sequential. The storage holds 2^ADDR_W bytes, so ADDR_W = 13 gives an 8192 x 8 array. The default is a smaller array so that elaboration stays light.

Written bytes are first gathered in a 32-byte page latch. They are committed to the array only after the master's STOP, during a program interval of fixed length that is shown on `busy_o`. Two inputs can block programming. A write-protect input guards the upper half of the array. A low-supply flag blocks programming while a write transfer is open. The block only pulls SDA low, through `sda_oe_o`; the bus pull-up supplies the high level.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A device-address byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal the CHIP_SEL parameter (default 000). Bit 0 selects the direction: 0 is write and 1 is read. Any other address byte gets no ACK, and SDA stays released.
- R2: In a write transfer, two word-address bytes follow the device address, high byte first, and each one is acknowledged. Bits of the high byte above the array width are ignored.
- R3: Data bytes of a write are acknowledged and land at successive addresses. Only the low 5 address bits advance, so a page write wraps within its 32-byte page.
- R4: Programming starts only at a STOP that ends a write with at least one acknowledged data byte. `busy_o` is then high for exactly PROG_CYCLES clocks. While busy, the device address gets no ACK.
- R5: With `wp_i` high, a write aimed at the upper half of the array (address MSB = 1) still has its device and word addresses acknowledged. Its first data byte gets no ACK, no program cycle follows, and the stored byte keeps its value. Lower-half writes are unaffected.
- R6: While a write transfer is open (from a R/W=0 device address to STOP), an asserted `low_supply_i` causes the next ACK to be withheld and inhibits programming at STOP.
- R7: An internal pointer holds the last accessed address plus one. A read that starts directly with a R/W=1 device address returns the byte at that pointer.
- R8: A random read returns the byte at the word address loaded by a dummy write that is followed by a repeated START and a R/W=1 device address.
- R9: A sequential read sends further bytes for each master ACK. The pointer wraps from the last address to 0. A master NACK ends the read and releases SDA.
- R10: A START or STOP seen in the middle of a byte aborts the transfer. After a START, a new device address is decoded normally. After a STOP, SDA is released and nothing is programmed.
- R11: After reset, SDA is released and `busy_o` is low.
- R12: The block changes its SDA drive only while SCL is low. An ACK or data bit stays stable throughout the SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wp_i | input | 1 | Write protect for the upper half of the array |
| low_supply_i | input | 1 | Supply-low flag that blocks programming |
| busy_o | output | 1 | High while a program cycle runs |

## Verification
The bench checks the page-wrap edge at the 32-byte boundary, where a design that carried into the page bits would write into the next page. It checks the pointer wrap from the last array address to zero, where a design that saturated or wrapped inside a page would return the wrong byte. Write protect is checked on the first data byte of an upper-half write, where a faulty design would acknowledge the byte or start a program cycle. The low-supply flag is raised midway through a write; a design that ignored it would overwrite the stored byte. Further cases probe a busy device, which must not ACK its address, and aborted transfers, where a missed mid-byte START or STOP leaves the bit counter misaligned or drives SDA stray.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    // transfer phase of the bus engine
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DEV  = 3'd1,
        S_AHI  = 3'd2,
        S_ALO  = 3'd3,
        S_WR   = 3'd4,
        S_RD   = 3'd5
    } xfer_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_p_q    <= 1'b1;
            sda_p_q    <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_p_q    <= scl_pipe_q[STAGES-1];
            sda_p_q    <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    // data edges while the clock is held high mark bus conditions
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/page_latch.sv
module page_latch #(
    parameter int PAGE = 32,
    localparam int IDX_W = $clog2(PAGE)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] slot [PAGE];

    always_ff @(posedge clk) begin
        if (we) slot[widx] <= wdata;
    end

    assign rdata = slot[ridx];
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
    import eeprom_i2c_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter int         PAGE        = 32,
    parameter int         PROG_CYCLES = 600,
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] CHIP_SEL    = 3'b000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic wp_i,
    input  logic low_supply_i,
    output logic busy_o
);
    localparam int PAGE_W = $clog2(PAGE);
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam int HI_W   = ADDR_W - 8;
    localparam int PCNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [PCNT_W-1:0] PAGE_CNT  = PCNT_W'(PAGE);
    localparam logic [PCNT_W-1:0] LAST_CNT  = PCNT_W'(PROG_CYCLES - 1);
    localparam logic [PCNT_W-1:0] PCNT_ONE  = 1;
    localparam logic [ADDR_W-1:0] PTR_ONE   = 1;
    localparam logic [PAGE_W-1:0] PIDX_ONE  = 1;

    typedef struct packed {
        xfer_e             st;
        logic [2:0]        cnt;
        logic              got;
        logic              ack;
        logic              oe;
        logic              rw;
        logic              mack;
        logic              first;
        logic              pend;
        logic              armed;
        logic              inhibit;
        logic              busy;
        logic [7:0]        sh;
        logic [HI_W-1:0]   ahi;
        logic [ADDR_W-1:0] ptr;
        logic [BASE_W-1:0] base;
        logic [PAGE-1:0]   valid;
        logic [PCNT_W-1:0] pcnt;
    } regs_t;

    regs_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_data, pb_rdata, pb_wdata;
    logic pb_we, mem_we, ack_now, wr_ok, match;
    logic [PAGE_W-1:0] pb_widx, commit_idx;
    logic [ADDR_W-1:0] mem_waddr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign commit_idx = q.pcnt[PAGE_W-1:0];
    assign mem_waddr  = {q.base, commit_idx};

    page_latch #(.PAGE(PAGE)) u_page (
        .clk(clk), .we(pb_we), .widx(pb_widx), .wdata(pb_wdata),
        .ridx(commit_idx), .rdata(pb_rdata)
    );

    eeprom_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pb_rdata),
        .raddr(q.ptr), .rdata(rd_data)
    );

    always_comb begin
        n        = q;
        pb_we    = 1'b0;
        pb_widx  = q.ptr[PAGE_W-1:0];
        pb_wdata = q.sh;
        mem_we   = 1'b0;
        ack_now  = 1'b0;
        wr_ok    = ~q.inhibit & ~low_supply_i;
        match    = (q.sh[7:4] == DEV_TYPE) && (q.sh[3:1] == CHIP_SEL);

        // program engine: walks the page latch, then holds busy
        if (q.busy) begin
            n.pcnt = q.pcnt + PCNT_ONE;
            if (q.pcnt < PAGE_CNT && q.valid[commit_idx]) mem_we = 1'b1;
            if (q.pcnt == LAST_CNT) begin
                n.busy  = 1'b0;
                n.valid = '0;
            end
        end

        if (start_det) begin
            n.st      = S_DEV;
            n.cnt     = 3'd0;
            n.got     = 1'b0;
            n.ack     = 1'b0;
            n.oe      = 1'b0;
            n.armed   = 1'b0;
            n.inhibit = 1'b0;
            n.pend    = 1'b0;
            n.first   = 1'b1;
            if (!q.busy) n.valid = '0;
        end else if (stop_det) begin
            n.st    = S_IDLE;
            n.oe    = 1'b0;
            n.ack   = 1'b0;
            n.got   = 1'b0;
            n.armed = 1'b0;
            n.pend  = 1'b0;
            if (q.pend && !q.inhibit && !q.busy && !(q.armed && low_supply_i)) begin
                n.busy = 1'b1;
                n.pcnt = '0;
            end
        end else if (q.st != S_IDLE) begin
            if (q.armed && low_supply_i) n.inhibit = 1'b1;

            if (q.st == S_RD) begin
                if (!q.ack) begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            n.oe  = 1'b0;
                            n.ack = 1'b1;
                            n.ptr = q.ptr + PTR_ONE;
                        end else begin
                            n.cnt = q.cnt + 3'd1;
                            n.sh  = {q.sh[6:0], 1'b0};
                            n.oe  = ~q.sh[6];
                        end
                    end
                end else begin
                    if (scl_rise) n.mack = ~sda_s;
                    if (scl_fall) begin
                        n.ack = 1'b0;
                        if (q.mack) begin
                            n.sh  = rd_data;
                            n.oe  = ~rd_data[7];
                            n.cnt = 3'd0;
                        end else begin
                            n.st = S_IDLE;
                            n.oe = 1'b0;
                        end
                    end
                end
            end else begin
                // receive phases share the bit shifter
                if (scl_rise && !q.ack && !q.got) begin
                    n.sh  = {q.sh[6:0], sda_s};
                    n.cnt = q.cnt + 3'd1;
                    if (q.cnt == 3'd7) n.got = 1'b1;
                end else if (scl_fall && q.got) begin
                    n.got = 1'b0;
                    unique case (q.st)
                        S_DEV: begin
                            n.rw    = q.sh[0];
                            n.armed = match & ~q.sh[0];
                            ack_now = match & ~q.busy & (q.sh[0] | ~low_supply_i);
                            if (match && !q.sh[0] && low_supply_i) n.inhibit = 1'b1;
                        end
                        S_AHI: begin
                            n.ahi   = q.sh[HI_W-1:0];
                            ack_now = wr_ok;
                        end
                        S_ALO: begin
                            n.ptr   = {q.ahi, q.sh};
                            ack_now = wr_ok;
                        end
                        default: begin
                            ack_now = wr_ok & ~(q.first & wp_i & q.ptr[ADDR_W-1]);
                            if (ack_now) begin
                                pb_we                 = 1'b1;
                                n.valid[pb_widx]      = 1'b1;
                                n.ptr[PAGE_W-1:0]     = q.ptr[PAGE_W-1:0] + PIDX_ONE;
                                n.pend                = 1'b1;
                                n.first               = 1'b0;
                                if (q.first) n.base   = q.ptr[ADDR_W-1:PAGE_W];
                            end
                        end
                    endcase
                    if (ack_now) begin
                        n.ack = 1'b1;
                        n.oe  = 1'b1;
                    end else begin
                        n.st = S_IDLE;
                        n.oe = 1'b0;
                    end
                end else if (scl_fall && q.ack) begin
                    n.ack = 1'b0;
                    n.oe  = 1'b0;
                    n.cnt = 3'd0;
                    unique case (q.st)
                        S_DEV: begin
                            if (q.rw) begin
                                n.st = S_RD;
                                n.sh = rd_data;
                                n.oe = ~rd_data[7];
                            end else begin
                                n.st = S_AHI;
                            end
                        end
                        S_AHI:   n.st = S_ALO;
                        default: n.st = S_WR;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_oe_o = q.oe;
    assign busy_o   = q.busy;
endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk #(
    parameter int PROG_CYCLES = 600
) (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic busy
);
    int unsigned busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len_q <= 0;
        else if (busy) busy_len_q <= busy_len_q + 1;
        else           busy_len_q <= 0;
    end

    // R12
    drive_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    // R4
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R4
    busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R4
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len_q == PROG_CYCLES);

    // R10
    cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start_det) || $past(stop_det)) |-> !sda_oe);
endmodule

bind eeprom_i2c_target eeprom_i2c_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe_o), .busy(busy_o)
);

// File: tb/eeprom_i2c_target_test.sv
`timescale 1ns/1ps
module eeprom_i2c_target_test;
    localparam int Q = 10;
    localparam int LIMIT = 180000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, wp = 1'b0, low = 1'b0;
    logic sda_oe, busy;
    wire  sda_line = sda_m & ~sda_oe;

    int tests = 0, fails = 0;
    bit done = 0;
    bit r12_bad = 0;
    logic [7:0] rbuf [0:7];

    always #10 clk = ~clk;

    eeprom_i2c_target #(.PROG_CYCLES(600)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .wp_i(wp), .low_supply_i(low), .busy_o(busy)
    );

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int k);
        for (int i = 7; i > 7 - k; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;   tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        logic oe_hi;
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(1);
            oe_hi = sda_oe;
            tick(Q - 1);
            b = {b[6:0], sda_line};
            tick(Q - 1);
            if (sda_oe !== oe_hi) r12_bad = 1;
            tick(1);
            scl = 1'b0;
        end
        tick(Q);
        sda_m = ~mack; tick(Q);
        scl = 1'b1;    tick(2 * Q);
        scl = 1'b0;    tick(1);
        sda_m = 1'b1;  tick(Q - 1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) tick(1);
    endtask

    task automatic write_page(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                              input logic [7:0] d2, input int k, input string req);
        logic ak;
        logic [7:0] dv [0:2];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        bus_start();
        send_byte(8'hA0, ak);  chk({req, " dev ack"}, ak, 1);
        send_byte(a[15:8], ak); chk({req, " addr hi ack"}, ak, 1);
        send_byte(a[7:0], ak);  chk({req, " addr lo ack"}, ak, 1);
        for (int i = 0; i < k; i++) begin
            send_byte(dv[i], ak); chk({req, " data ack"}, ak, 1);
        end
        bus_stop();
        tick(4);
        wait_idle();
    endtask

    task automatic read_seq(input logic [15:0] a, input int k);
        logic ak;
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(a[15:8], ak);
        send_byte(a[7:0], ak);
        bus_start();
        send_byte(8'hA1, ak);
        for (int i = 0; i < k; i++) recv_byte(i < k - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic read_cur(input int k);
        logic ak;
        bus_start();
        send_byte(8'hA1, ak);
        for (int i = 0; i < k; i++) recv_byte(i < k - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R11 sda released", sda_oe, 0);
        chk("R11 busy low", busy, 0);
    endtask

    task automatic t_devsel();
        logic ak;
        bus_start(); send_byte(8'hB0, ak); chk("R1 wrong type nack", ak, 0);
        chk("R1 no drive after nack", sda_oe, 0); bus_stop();
        bus_start(); send_byte(8'hA2, ak); chk("R1 wrong chip select nack", ak, 0); bus_stop();
    endtask

    task automatic t_page_write();
        logic ak;
        bus_start();
        send_byte(8'hA0, ak); chk("R1 dev ack", ak, 1);
        send_byte(8'hF8, ak); chk("R2 hi ack", ak, 1);
        send_byte(8'h10, ak); chk("R2 lo ack", ak, 1);
        send_byte(8'h11, ak); chk("R3 data ack", ak, 1);
        send_byte(8'h22, ak); chk("R3 data ack", ak, 1);
        send_byte(8'h33, ak); chk("R3 data ack", ak, 1);
        send_byte(8'h44, ak); chk("R3 data ack", ak, 1);
        chk("R4 no busy before stop", busy, 0);
        bus_stop();
        chk("R4 busy after stop", busy, 1);
        bus_start(); send_byte(8'hA0, ak); chk("R4 nack while busy", ak, 0); bus_stop();
        wait_idle();
        chk("R4 busy ends", busy, 0);
        read_seq(16'h0010, 4);
        chk("R2 byte0 high bits ignored", rbuf[0], 8'h11);
        chk("R9 seq byte1", rbuf[1], 8'h22);
        chk("R9 seq byte2", rbuf[2], 8'h33);
        chk("R9 seq byte3", rbuf[3], 8'h44);
    endtask

    task automatic t_random_current();
        read_seq(16'h0011, 1);
        chk("R8 random read", rbuf[0], 8'h22);
        read_cur(1);
        chk("R7 current read", rbuf[0], 8'h33);
    endtask

    task automatic t_wrap();
        write_page(16'h003E, 8'hAA, 8'hBB, 8'hCC, 3, "R3");
        read_seq(16'h003E, 2);
        chk("R3 before wrap", rbuf[0], 8'hAA);
        chk("R3 page end", rbuf[1], 8'hBB);
        read_seq(16'h0020, 1);
        chk("R3 wrapped into page start", rbuf[0], 8'hCC);
    endtask

    task automatic t_wp();
        logic ak;
        write_page(16'h0400, 8'h5A, 8'h00, 8'h00, 1, "R5 setup");
        wp = 1'b1;
        bus_start();
        send_byte(8'hA0, ak); chk("R5 dev ack", ak, 1);
        send_byte(8'h04, ak); chk("R5 hi ack", ak, 1);
        send_byte(8'h00, ak); chk("R5 lo ack", ak, 1);
        send_byte(8'hA5, ak); chk("R5 data nack", ak, 0);
        bus_stop();
        chk("R5 no program", busy, 0);
        read_seq(16'h0400, 1);
        chk("R5 upper kept", rbuf[0], 8'h5A);
        write_page(16'h0100, 8'h77, 8'h00, 8'h00, 1, "R5 lower");
        read_seq(16'h0100, 1);
        chk("R5 lower written", rbuf[0], 8'h77);
        wp = 1'b0;
    endtask

    task automatic t_lockout();
        logic ak;
        low = 1'b1;
        bus_start(); send_byte(8'hA0, ak); chk("R6 dev nack on low supply", ak, 0); bus_stop();
        chk("R6 no busy", busy, 0);
        low = 1'b0;
        write_page(16'h0050, 8'h66, 8'h00, 8'h00, 1, "R6 setup");
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h00, ak);
        send_byte(8'h50, ak);
        send_byte(8'h99, ak); chk("R6 first data ack", ak, 1);
        low = 1'b1;
        send_byte(8'h98, ak); chk("R6 data nack on low supply", ak, 0);
        low = 1'b0;
        bus_stop();
        chk("R6 program inhibited", busy, 0);
        read_seq(16'h0050, 1);
        chk("R6 byte kept", rbuf[0], 8'h66);
    endtask

    task automatic t_roll();
        write_page(16'h07FE, 8'hD1, 8'hD2, 8'h00, 2, "R9 setup hi");
        write_page(16'h0000, 8'hD3, 8'h00, 8'h00, 1, "R9 setup lo");
        read_seq(16'h07FE, 3);
        chk("R9 last-1", rbuf[0], 8'hD1);
        chk("R9 last", rbuf[1], 8'hD2);
        chk("R9 rolled to 0", rbuf[2], 8'hD3);
        chk("R9 released after nack", sda_oe, 0);
    endtask

    task automatic t_abort();
        logic ak;
        read_seq(16'h0012, 1);
        bus_start();
        send_bits(8'hA0, 4);
        bus_start();
        send_byte(8'hA1, ak); chk("R10 ack after mid-byte start", ak, 1);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
        chk("R10 read after restart", rbuf[0], 8'h44);
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h00, ak);
        send_bits(8'h60, 3);
        bus_stop();
        chk("R10 released after mid-byte stop", sda_oe, 0);
        chk("R10 no program after stop", busy, 0);
        chk("R12 drive stable while scl high", r12_bad, 0);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_devsel();
        t_page_write();
        t_random_current();
        t_wrap();
        t_wp();
        t_lockout();
        t_roll();
        t_abort();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule